// File: doc/BRIEF.md
# HDLC Receive Flag and Abort Detector

This block sits on a serial HDLC receive line and takes one bit each time its bit strobe is high. It finds flags, abort runs and the go-ahead pattern, removes the zero inserted after five ones inside a frame, and counts the payload bits received since the last flag. The packet length tells the block whether a packet is a whole number of bytes, so it can class the packet as good or invalid.

The outputs are single-cycle pulses. A pulse marks the start of a frame. A pulse ends each packet and carries an ending code and the payload length. A separate pulse reports a frame abort, but only when the packet was long enough. Another pulse reports go-ahead. An overflow input from the storage stage that follows turns reception off. Reception comes back on by itself at the next flag. CRC checking and data storage belong to other blocks.

Top module: `hdlc_rxdet`

## Requirements
- R1: While reset is held and right after it, `rx_on`, `frame_start`, `eop`, `frame_abort`, `go_ahead` and `bit_count` are all zero.
- R2: A flag is a zero that follows exactly six ones, seen as the bit sequence 0,1,1,1,1,1,1,0. A flag turns reception on (`rx_on` = 1) from the cycle after its last bit.
- R3: `frame_start` pulses once per packet, on the 8th counted bit after a flag. A packet closed by a flag with a payload length that is a multiple of 8 gives one `eop` pulse with `eop_kind` = 0 and `pkt_bits` = payload length.
- R4: A packet closed by a flag with a payload length that is not a multiple of 8 gives one `eop` pulse with `eop_kind` = 2 (invalid) and `pkt_bits` = payload length.
- R5: Two flags in a row, including flags that share a zero, are idle fill. They produce no `frame_start` and no `eop`.
- R6: Inside a frame, a zero that follows five ones is deleted. It is counted neither in `bit_count` (counted bits since the last flag) nor in `pkt_bits`.
- R7: Seven ones in a row are an abort. If a frame has started, the abort gives one `eop` with `eop_kind` = 1 and `pkt_bits` = the bits before the run of ones. An abort before the 8th counted bit is silent. In every case `rx_on` drops until the next flag.
- R8: `frame_abort` pulses together with an abort `eop` only when `pkt_bits` is at least 26. An abort after fewer bits raises no `frame_abort`.
- R9: A high `ovf_in` drops `rx_on` from the next cycle. Bits that follow raise no packet event until a flag turns reception on again.
- R10: `go_ahead` pulses once, for one cycle, when the last eight bits are 0 followed by seven ones. This works whatever the reception state. Further ones raise no further pulse.
- R11: Cycles with `bit_en` low change no count and raise no pulse, whatever `rx_bit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Strobe: `rx_bit` is valid in this cycle |
| rx_bit | input | 1 | Serial receive data |
| ovf_in | input | 1 | Receive storage overflow; turns reception off |
| rx_on | output | 1 | Reception enabled (a flag has been seen) |
| frame_start | output | 1 | Pulse: a packet has begun |
| eop | output | 1 | Pulse: a packet has ended |
| eop_kind | output | 2 | Ending code with `eop`: 0 good, 1 abort, 2 invalid |
| frame_abort | output | 1 | Pulse: abort after at least 26 packet bits |
| go_ahead | output | 1 | Pulse: go-ahead pattern seen |
| pkt_bits | output | CNT_W | Payload length in bits, valid with `eop` |
| bit_count | output | CNT_W | Counted bits since the last flag |

## Verification
The bench sweeps the payload length from 1 to 40 bits under two data patterns. One pattern is all ones, so the stuffed zeros sit right against the closing flag. It also aborts packets of every length from 1 to 40. This covers the byte-multiple boundary, where an off-by-one in the flag-body subtraction would turn good packets invalid. It covers the 25/26-bit abort threshold, where a wrong compare shifts `frame_abort` by one length. It covers the 1-bit abort that must stay silent. Further cases check that shared-zero flags and an overflow in mid-packet raise no `eop`. They check that a long run of ones gives exactly one go-ahead. They also check that a counter which kept stuffed zeros or ran during idle strobes would report wrong lengths.

// File: rtl/hdlc_rxdet_pkg.sv
`timescale 1ns/1ps
// Shared types of the HDLC receive flag and abort detector.
package hdlc_rxdet_pkg;
    // Ending code reported with each end-of-packet pulse
    typedef enum logic [1:0] {
        EOP_GOOD    = 2'd0,
        EOP_ABORT   = 2'd1,
        EOP_INVALID = 2'd2
    } eop_kind_e;

    // Reception state: hunting for a flag, between flags, inside a packet
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FRAME = 2'd2
    } rx_state_e;
endpackage

// File: rtl/hdlc_rxdet_scan.sv
`timescale 1ns/1ps
// Pattern scanner. It keeps a window of recent bits and a run length of ones.
// It flags, for the bit now offered, a closing flag zero, the seventh one of
// an abort, a stuffed zero, and a completed go-ahead pattern.
// Assumes: the hit outputs matter only when bit_en is high.
module hdlc_rxdet_scan #(
    parameter int RUN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic flag_hit,
    output logic abort_hit,
    output logic stuff_hit,
    output logic ga_hit
);
    localparam int FLAG_ONES  = 6;
    localparam int STUFF_ONES = 5;
    localparam int WIN_W      = FLAG_ONES + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [WIN_W-1:0] win_q;
    logic [RUN_W-1:0] ones_q;

    // Shift the window and track the run of ones on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '1;
            ones_q <= '0;
        end else if (bit_en) begin
            win_q  <= {win_q[WIN_W-2:0], rx_bit};
            if (rx_bit)
                ones_q <= (ones_q == RUN_MAX) ? ones_q : ones_q + 1'b1;
            else
                ones_q <= '0;
        end
    end

    // Decode the offered bit against the current run and window
    always_comb begin
        flag_hit  = !rx_bit && (ones_q == RUN_W'(FLAG_ONES));
        abort_hit =  rx_bit && (ones_q == RUN_W'(FLAG_ONES));
        stuff_hit = !rx_bit && (ones_q == RUN_W'(STUFF_ONES));
        ga_hit    = ({win_q, rx_bit} == {1'b0, {WIN_W{1'b1}}});
    end
endmodule

// File: rtl/hdlc_rxdet_len.sv
`timescale 1ns/1ps
// Bit counter. It counts the bits accepted since the last flag, abort or
// overflow, and stops at its maximum value.
// Assumes: clr takes priority over inc.
module hdlc_rxdet_len #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Clear, or count up with saturation
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/hdlc_rxdet_ctl.sv
`timescale 1ns/1ps
// Frame controller. From the scanner hits and the bit count it tracks the
// reception state, decides on packet start and end, classifies the ending,
// and drives all pulse outputs as registers.
// Assumes: the counted bits at a closing flag include the seven flag bits
// before its last zero; at an abort they include the six leading ones.
module hdlc_rxdet_ctl
    import hdlc_rxdet_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int MIN_ABORT_BITS = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             ovf_in,
    input  logic             flag_hit,
    input  logic             abort_hit,
    input  logic             stuff_hit,
    input  logic             ga_hit,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             rx_on,
    output logic             frame_start,
    output logic             eop,
    output logic [1:0]       eop_kind,
    output logic             frame_abort,
    output logic             go_ahead,
    output logic [CNT_W-1:0] pkt_bits
);
    localparam logic [CNT_W-1:0] FLAG_BODY  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ABORT_BODY = CNT_W'(6);
    localparam logic [CNT_W-1:0] ABORT_CNT  = CNT_W'(MIN_ABORT_BITS + 6);

    rx_state_e        st_q;
    eop_kind_e        kind_q;
    logic             start_q, eop_q, fa_q, ga_q;
    logic [CNT_W-1:0] bits_q;

    // Counter control: restart on flag, abort or overflow; count kept bits
    always_comb begin
        cnt_clr = ovf_in || (bit_en && (flag_hit || abort_hit));
        cnt_inc = bit_en && !ovf_in && !flag_hit && !abort_hit && !stuff_hit
                  && (st_q != ST_HUNT);
    end

    // State transitions and registered event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_HUNT;
            kind_q  <= EOP_GOOD;
            start_q <= 1'b0;
            eop_q   <= 1'b0;
            fa_q    <= 1'b0;
            ga_q    <= 1'b0;
            bits_q  <= '0;
        end else begin
            start_q <= 1'b0;
            eop_q   <= 1'b0;
            fa_q    <= 1'b0;
            ga_q    <= bit_en && ga_hit;
            if (ovf_in) begin
                st_q <= ST_HUNT;
            end else if (bit_en) begin
                if (flag_hit) begin
                    if (st_q == ST_FRAME) begin
                        eop_q  <= 1'b1;
                        kind_q <= (cnt[2:0] == 3'b111) ? EOP_GOOD : EOP_INVALID;
                        bits_q <= cnt - FLAG_BODY;
                    end
                    st_q <= ST_IDLE;
                end else if (abort_hit) begin
                    if (st_q == ST_FRAME) begin
                        eop_q  <= 1'b1;
                        kind_q <= EOP_ABORT;
                        bits_q <= cnt - ABORT_BODY;
                        fa_q   <= (cnt >= ABORT_CNT);
                    end
                    st_q <= ST_HUNT;
                end else if (!stuff_hit && st_q == ST_IDLE && cnt == FLAG_BODY) begin
                    start_q <= 1'b1;
                    st_q    <= ST_FRAME;
                end
            end
        end
    end

    assign rx_on       = (st_q != ST_HUNT);
    assign frame_start = start_q;
    assign eop         = eop_q;
    assign eop_kind    = kind_q;
    assign frame_abort = fa_q;
    assign go_ahead    = ga_q;
    assign pkt_bits    = bits_q;
endmodule

// File: rtl/hdlc_rxdet.sv
`timescale 1ns/1ps
// HDLC receive flag and abort detector, top level. It joins the pattern
// scanner, the bit counter and the frame controller.
// Assumes: one serial bit per cycle with bit_en high; ovf_in may come at any cycle.
module hdlc_rxdet #(
    parameter int CNT_W          = 16,
    parameter int MIN_ABORT_BITS = 26,
    parameter int RUN_W          = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             ovf_in,
    output logic             rx_on,
    output logic             frame_start,
    output logic             eop,
    output logic [1:0]       eop_kind,
    output logic             frame_abort,
    output logic             go_ahead,
    output logic [CNT_W-1:0] pkt_bits,
    output logic [CNT_W-1:0] bit_count
);
    logic             flag_hit, abort_hit, stuff_hit, ga_hit;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;

    hdlc_rxdet_scan #(.RUN_W(RUN_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .flag_hit(flag_hit), .abort_hit(abort_hit),
        .stuff_hit(stuff_hit), .ga_hit(ga_hit)
    );

    hdlc_rxdet_len #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    hdlc_rxdet_ctl #(.CNT_W(CNT_W), .MIN_ABORT_BITS(MIN_ABORT_BITS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ovf_in(ovf_in),
        .flag_hit(flag_hit), .abort_hit(abort_hit), .stuff_hit(stuff_hit),
        .ga_hit(ga_hit), .cnt(cnt), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .rx_on(rx_on), .frame_start(frame_start), .eop(eop),
        .eop_kind(eop_kind), .frame_abort(frame_abort), .go_ahead(go_ahead),
        .pkt_bits(pkt_bits)
    );

    assign bit_count = cnt;
endmodule

// File: rtl/hdlc_rxdet_chk.sv
`timescale 1ns/1ps
// Property checker for hdlc_rxdet. It sees only the ports of the top and is
// attached through the bind statement at the end of this file.
module hdlc_rxdet_chk #(
    parameter int CNT_W          = 16,
    parameter int MIN_ABORT_BITS = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             ovf_in,
    input logic             rx_on,
    input logic             frame_start,
    input logic             eop,
    input logic [1:0]       eop_kind,
    input logic             frame_abort,
    input logic             go_ahead,
    input logic [CNT_W-1:0] pkt_bits
);
    // R3: a packet only starts while reception is on
    a_r3_start_on: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> rx_on);

    // R3: a good ending always has a whole number of bytes
    a_r3_good_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (eop && eop_kind == 2'd0) |-> (pkt_bits[2:0] == 3'd0 && pkt_bits != '0));

    // R4: an invalid ending never has a whole number of bytes
    a_r4_invalid_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (eop && eop_kind == 2'd2) |-> (pkt_bits[2:0] != 3'd0));

    // R7: a frame abort always comes with an abort ending
    a_r7_fa_is_abort: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> (eop && eop_kind == 2'd1));

    // R8: a frame abort needs the minimum packet length
    a_r8_fa_len: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> (pkt_bits >= CNT_W'(MIN_ABORT_BITS)));

    // R9: overflow turns reception off in the next cycle
    a_r9_ovf_off: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_in |=> !rx_on);

    // R10: go-ahead is a single-cycle pulse
    a_r10_ga_single: assert property (@(posedge clk) disable iff (!rst_n)
        go_ahead |=> !go_ahead);

    // R11: no event follows a cycle without a strobe
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!eop && !frame_start && !go_ahead && !frame_abort));
endmodule

bind hdlc_rxdet hdlc_rxdet_chk #(
    .CNT_W(CNT_W), .MIN_ABORT_BITS(MIN_ABORT_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ovf_in(ovf_in),
    .rx_on(rx_on), .frame_start(frame_start), .eop(eop),
    .eop_kind(eop_kind), .frame_abort(frame_abort), .go_ahead(go_ahead),
    .pkt_bits(pkt_bits)
);

// File: tb/hdlc_rxdet_test.sv
`timescale 1ns/1ps
// Self-checking bench for hdlc_rxdet. It sweeps packet lengths and endings
// and computes the expected events from the requirements.
module hdlc_rxdet_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             rx_bit = 1'b0;
    logic             ovf_in = 1'b0;
    logic             rx_on, frame_start, eop, frame_abort, go_ahead;
    logic [1:0]       eop_kind;
    logic [CNT_W-1:0] pkt_bits, bit_count;

    int errs = 0;
    int checks = 0;
    int n_fs, n_eop, n_fa, n_ga, last_kind, last_bits;
    int run1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hdlc_rxdet #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ovf_in(ovf_in), .rx_on(rx_on), .frame_start(frame_start), .eop(eop),
        .eop_kind(eop_kind), .frame_abort(frame_abort), .go_ahead(go_ahead),
        .pkt_bits(pkt_bits), .bit_count(bit_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_acc();
        n_fs = 0; n_eop = 0; n_fa = 0; n_ga = 0; last_kind = -1; last_bits = -1;
    endtask

    // One strobed bit, then one idle cycle with the line toggled (R11)
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1; rx_bit = b;
        @(negedge clk);
        bit_en = 1'b0; rx_bit = ~b;
        if (frame_start) n_fs++;
        if (eop) begin n_eop++; last_kind = int'(eop_kind); last_bits = int'(pkt_bits); end
        if (frame_abort) n_fa++;
        if (go_ahead) n_ga++;
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int k = 0; k < 6; k++) send_bit(1'b1);
        send_bit(1'b0);
        run1 = 0;
    endtask

    // Payload bit with zero insertion after five ones
    task automatic send_data(input logic b);
        send_bit(b);
        if (b) begin
            run1++;
            if (run1 == 5) begin send_bit(1'b0); run1 = 0; end
        end else run1 = 0;
    endtask

    function automatic logic pbit(input int pat, input int len, input int i);
        if (pat == 0) return 1'b1;
        return ((i * 3 + len) % 7) != 0;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        clear_acc();
        run1 = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rx_on", int'(rx_on), 0);
        chk("R1 pulses", int'(frame_start | eop | frame_abort | go_ahead), 0);
        chk("R1 bit_count", int'(bit_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_on after release", int'(rx_on), 0);

        // R2: first flag turns reception on
        send_flag();
        chk("R2 rx_on after flag", int'(rx_on), 1);

        // R3 R4 R5 R6: flag-closed packets of every length, two patterns
        for (int pat = 0; pat < 2; pat++) begin
            for (int len = 1; len <= 40; len++) begin
                clear_acc();
                send_flag();
                chk("R5 back-to-back flag eop", n_eop, 0);
                for (int i = 0; i < len; i++) send_data(pbit(pat, len, i));
                send_flag();
                chk("R3 frame_start count", n_fs, 1);
                chk("R3 eop count", n_eop, 1);
                chk((len % 8 == 0) ? "R3 kind good" : "R4 kind invalid",
                    last_kind, (len % 8 == 0) ? 0 : 2);
                chk("R6 pkt_bits excludes stuffed zeros", last_bits, len);
                chk("R10 no go-ahead in frames", n_ga, 0);
                chk("R8 no frame_abort on flag end", n_fa, 0);
            end
        end

        // R7 R8 R10: aborted packets of every length
        for (int len = 1; len <= 40; len++) begin
            send_flag();
            chk("R2 rx_on re-enabled", int'(rx_on), 1);
            clear_acc();
            for (int i = 0; i < len; i++)
                send_data((i == len - 1) ? 1'b0 : logic'(i % 4 == 1));
            for (int k = 0; k < 7; k++) send_bit(1'b1);
            chk("R7 abort eop count", n_eop, (len >= 2) ? 1 : 0);
            if (len >= 2) begin
                chk("R7 abort kind", last_kind, 1);
                chk("R7 abort pkt_bits", last_bits, len);
            end
            chk("R8 frame_abort threshold", n_fa, (len >= 26) ? 1 : 0);
            chk("R10 go-ahead on 0+seven ones", n_ga, 1);
            chk("R7 rx_on off after abort", int'(rx_on), 0);
        end

        // R5: flags sharing a zero
        send_flag();
        clear_acc();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 6; k++) send_bit(1'b1);
            send_bit(1'b0);
        end
        chk("R5 shared-zero eop", n_eop, 0);
        chk("R5 shared-zero frame_start", n_fs, 0);
        chk("R5 rx_on stays", int'(rx_on), 1);

        // R6: bit_count skips the stuffed zero
        send_flag();
        for (int k = 0; k < 5; k++) send_data(1'b1);
        chk("R6 bit_count after stuffing", int'(bit_count), 5);
        send_data(1'b0); send_data(1'b0);
        chk("R6 bit_count plain", int'(bit_count), 7);

        // R11: idle cycles with a busy line change nothing
        clear_acc();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rx_bit = logic'(k % 2);
        end
        @(negedge clk);
        chk("R11 bit_count held", int'(bit_count), 7);
        chk("R11 no events", n_eop + n_fs + n_ga, 0);

        // R10: long run of ones gives a single go-ahead
        send_flag();
        clear_acc();
        send_bit(1'b0);
        for (int k = 0; k < 10; k++) send_bit(1'b1);
        chk("R10 single go-ahead", n_ga, 1);
        chk("R7 early abort silent", n_eop, 0);

        // R9: overflow mid-packet
        send_flag();
        clear_acc();
        for (int i = 0; i < 12; i++) send_data(logic'(i % 3 == 0));
        @(negedge clk); ovf_in = 1'b1;
        @(negedge clk); ovf_in = 1'b0;
        chk("R9 rx_on off", int'(rx_on), 0);
        clear_acc();
        for (int i = 0; i < 12; i++) send_data(logic'(i % 2 == 0));
        chk("R9 no events while off", n_eop + n_fs, 0);
        send_flag();
        chk("R9 no eop at re-enabling flag", n_eop, 0);
        chk("R9 rx_on back", int'(rx_on), 1);
        clear_acc();
        for (int i = 0; i < 16; i++) send_data(logic'((16'hA5C3 >> i) & 1));
        send_flag();
        chk("R9 packet after recovery eop", n_eop, 1);
        chk("R9 packet after recovery kind", last_kind, 0);
        chk("R9 packet after recovery bits", last_bits, 16);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule